// File: doc/BRIEF.md
# Privilege-checked control register file

This block is a small control/status register file in which every software access is vetted before it has any effect. Each request presents a 12-bit register address, a read/write direction, write data and the privilege mode the requester is running in. Combinationally, in the same cycle, the block either grants the access or flags an illegal-instruction exception. A granted read returns the register value. A granted write updates the register at the next clock edge. A denied access returns zero and changes nothing.

The address itself carries the policy. Bits [9:8] give the lowest privilege level allowed to touch the register, and bits [11:10] equal to 11 make it read-only. A small window of addresses is reserved for debug mode alone. The file holds these registers:
- three scratch registers, one per non-machine level;
- an exception program counter that belongs to machine mode;
- a constant identification register;
- a debug scratch register;
- a key register.

The key register takes writes from machine rights and drives its value only to a hardware consumer. Software always reads it as zero.

Top module: `csr_guard`

## Requirements
- R1: After reset every stored register reads as zero, and the identification register (0xC12) reads as the ID_VALUE parameter.
- R2: Mode codes are 0 user, 1 supervisor, 2 hypervisor, 3 machine and 4 debug. Codes 5 to 7 carry user rights, and debug carries machine rights. Levels are user 0, supervisor 1, hypervisor 2 and machine 3. An access to a mapped register is granted only if the mode's level is at least addr[9:8]. The scratch register for level L (L = 0, 1, 2) sits at 0x040 | (L << 8).
- R3: A write to any address with addr[11:10] = 11 raises the exception, and the register keeps its contents.
- R4: The exception program counter at 0x341 is readable and writable only from machine or debug mode. Every other mode code gets the exception.
- R5: On a denied access, read data is zero and no register changes in that cycle.
- R6: Grant and exception are never both high. Both are low when no request is present. Both are valid in the cycle of the request.
- R7: A read of the key register (0x3C0) from any mode is granted and returns zero. A write to it is granted only from machine or debug mode, and the written value appears on key_o after the clock edge.
- R8: Addresses 0x7B0 to 0x7BF are accessible only in debug mode. The debug scratch register sits at 0x7B0.
- R9: Bit 0 of the exception program counter is forced to zero on every write.
- R10: A request to an address that maps no register raises the exception.
- R11: A granted write is visible to a granted read from the next cycle on. A granted write returns zero read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Access request present |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Register address carrying the policy bits |
| wdata_i | input | DATA_W | Write data |
| mode_i | input | 3 | Current privilege mode code |
| rdata_o | output | DATA_W | Read data, zero unless a read is granted |
| grant_o | output | 1 | Access accepted this cycle |
| illegal_o | output | 1 | Illegal-instruction exception this cycle |
| key_o | output | DATA_W | Key value to the hardware consumer |

## Verification
The bench sweeps every one of the 4096 addresses for both read and write under all eight mode codes. It keeps a model of every register, so a leak of any unmapped alias or a wrong level compare shows up as a wrong grant or wrong data. The corner cases it targets have sharp signatures:
- An exception program counter that lets lower modes in returns live data with grant high.
- A key read path that is still wired returns the key value.
- A write to a read-only address that is not blocked changes the identification value, or is granted.
- Debug-window registers open to machine mode grant where the exception is expected.
- A missing bit-0 clear leaves odd values readable.

// File: rtl/csr_guard_pkg.sv
package csr_guard_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned NUM_SCR = 3;

  localparam logic [2:0] MODE_USER = 3'd0;
  localparam logic [2:0] MODE_SUP  = 3'd1;
  localparam logic [2:0] MODE_HYP  = 3'd2;
  localparam logic [2:0] MODE_MACH = 3'd3;
  localparam logic [2:0] MODE_DBG  = 3'd4;

  localparam logic [ADDR_W-1:0] A_EPC = 12'h341;
  localparam logic [ADDR_W-1:0] A_ID  = 12'hC12;
  localparam logic [ADDR_W-1:0] A_KEY = 12'h3C0;
  localparam logic [ADDR_W-1:0] A_DBG = 12'h7B0;
  localparam logic [7:0]        A_SCR_LO = 8'h40;
  localparam logic [7:0]        A_DBG_HI = 8'h7B;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SCR, SEL_EPC, SEL_ID, SEL_KEY, SEL_DBG
  } reg_sel_e;
endpackage

// File: rtl/csr_rst_sync.sv
module csr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/csr_policy.sv
module csr_policy
  import csr_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        mode_i,
  output reg_sel_e          sel_o,
  output logic [1:0]        scr_idx_o,
  output logic              grant_o,
  output logic              illegal_o
);
  logic [1:0] level;
  logic [1:0] need;
  logic       ro_attr;
  logic       dbg_win;
  logic       key_rd;
  logic       allowed;

  always_comb begin
    unique case (mode_i)
      MODE_USER: level = 2'd0;
      MODE_SUP:  level = 2'd1;
      MODE_HYP:  level = 2'd2;
      MODE_MACH: level = 2'd3;
      MODE_DBG:  level = 2'd3;
      default:   level = 2'd0;
    endcase
  end

  always_comb begin
    sel_o     = SEL_NONE;
    scr_idx_o = addr_i[9:8];
    if (addr_i[11:10] == 2'b00 && addr_i[7:0] == A_SCR_LO && addr_i[9:8] != 2'b11)
      sel_o = SEL_SCR;
    else if (addr_i == A_EPC) sel_o = SEL_EPC;
    else if (addr_i == A_ID)  sel_o = SEL_ID;
    else if (addr_i == A_KEY) sel_o = SEL_KEY;
    else if (addr_i == A_DBG) sel_o = SEL_DBG;
  end

  assign need    = addr_i[9:8];
  assign ro_attr = (addr_i[11:10] == 2'b11);
  assign dbg_win = (addr_i[11:4] == A_DBG_HI);
  assign key_rd  = (sel_o == SEL_KEY) && !we_i;

  always_comb begin
    allowed = 1'b0;
    if (sel_o != SEL_NONE) begin
      if (key_rd)                            allowed = 1'b1;
      else if (we_i && ro_attr)              allowed = 1'b0;
      else if (dbg_win && mode_i != MODE_DBG) allowed = 1'b0;
      else                                   allowed = (level >= need);
    end
  end

  assign grant_o   = req_i && allowed;
  assign illegal_o = req_i && !allowed;

  // R3
  ro_write_trap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && we_i && addr_i[11:10] == 2'b11) |-> (illegal_o && !grant_o));

  // R8
  dbg_window_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && addr_i[11:4] == 8'h7B && mode_i != 3'd4) |-> illegal_o);

  // R7
  key_read_ok_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_i && !we_i && addr_i == 12'h3C0) |-> grant_o);
endmodule

// File: rtl/csr_store.sv
module csr_store
  import csr_guard_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic [1:0]        scr_idx,
  input  logic [2:0]        mode_i,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] key_o
);
  logic [DATA_W-1:0] scr_q [NUM_SCR];
  logic [DATA_W-1:0] scr_d [NUM_SCR];
  logic [DATA_W-1:0] epc_q, epc_d, dbg_q, dbg_d, key_q, key_d;
  logic              epc_en, dbg_en, key_en;

  genvar g;
  generate
    for (g = 0; g < NUM_SCR; g++) begin : g_scr
      logic en;
      assign en = wr_en && (sel == SEL_SCR) && (scr_idx == 2'(g));
      always_comb scr_d[g] = en ? wdata : scr_q[g];
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) scr_q[g] <= '0;
        else             scr_q[g] <= scr_d[g];
      end
    end
  endgenerate

  assign epc_en = wr_en && (sel == SEL_EPC);
  assign dbg_en = wr_en && (sel == SEL_DBG);
  assign key_en = wr_en && (sel == SEL_KEY);

  always_comb begin
    epc_d = epc_en ? {wdata[DATA_W-1:1], 1'b0} : epc_q;
    dbg_d = dbg_en ? wdata : dbg_q;
    key_d = key_en ? wdata : key_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      epc_q <= '0;
      dbg_q <= '0;
      key_q <= '0;
    end else begin
      epc_q <= epc_d;
      dbg_q <= dbg_d;
      key_q <= key_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_SCR: rdata = (scr_idx < 2'(NUM_SCR)) ? scr_q[scr_idx] : '0;
        SEL_EPC: rdata = epc_q;
        SEL_ID:  rdata = ID_VALUE;
        SEL_DBG: rdata = dbg_q;
        default: rdata = '0;
      endcase
    end
  end

  assign key_o = key_q;

  // R4
  epc_guard_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_EPC && mode_i != 3'd3 && mode_i != 3'd4) |=> $stable(epc_q));

  // R9
  epc_even_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    epc_q[0] == 1'b0);
endmodule

// File: rtl/csr_guard.sv
module csr_guard
  import csr_guard_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] ID_VALUE = 32'h5A17_0C01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [11:0]       addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [2:0]        mode_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              grant_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] key_o
);
  logic     rst_sync_n;
  reg_sel_e sel;
  logic [1:0] scr_idx;

  csr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  csr_policy u_policy (
    .clk(clk), .rst_sync_n(rst_sync_n), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .mode_i(mode_i), .sel_o(sel), .scr_idx_o(scr_idx),
    .grant_o(grant_o), .illegal_o(illegal_o)
  );

  csr_store #(.DATA_W(DATA_W), .ID_VALUE(ID_VALUE)) u_store (
    .clk(clk), .rst_sync_n(rst_sync_n),
    .wr_en(grant_o && we_i), .rd_en(grant_o && !we_i),
    .sel(sel), .scr_idx(scr_idx), .mode_i(mode_i), .wdata(wdata_i),
    .rdata(rdata_o), .key_o(key_o)
  );

  // R6
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({grant_o, illegal_o}) && (req_i || (!grant_o && !illegal_o)));

  // R5
  deny_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    illegal_o |-> (rdata_o == '0));

  // R7
  key_no_leak_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_i == 12'h3C0) |-> (rdata_o == '0));
endmodule

// File: tb/test_csr_guard.sv
module test_csr_guard;
  localparam logic [31:0] IDV = 32'h5A17_0C01;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [2:0]  mode = '0;
  logic [31:0] rdata, key;
  logic        grant, illegal;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_scr [3];
  logic [31:0] m_epc, m_dbg, m_key;

  always #4 clk = ~clk;

  csr_guard #(.DATA_W(32), .ID_VALUE(IDV)) i_csr_guard (
    .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mode_i(mode), .rdata_o(rdata), .grant_o(grant),
    .illegal_o(illegal), .key_o(key)
  );

  task automatic chk(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit mapped(input logic [11:0] a);
    return (a == 12'h040) || (a == 12'h140) || (a == 12'h240) || (a == 12'h341) ||
           (a == 12'hC12) || (a == 12'h3C0) || (a == 12'h7B0);
  endfunction

  function automatic bit exp_ok(input logic [2:0] md, input bit w, input logic [11:0] a);
    int lvl;
    lvl = (md == 3 || md == 4) ? 3 : (md < 3 ? int'(md) : 0);
    if (!mapped(a)) return 0;
    if (a == 12'h3C0 && !w) return 1;
    if (w && a[11:10] == 2'b11) return 0;
    if (a >= 12'h7B0 && a <= 12'h7BF && md != 4) return 0;
    return lvl >= int'(a[9:8]);
  endfunction

  function automatic logic [31:0] exp_val(input logic [11:0] a);
    case (a)
      12'h040: return m_scr[0];
      12'h140: return m_scr[1];
      12'h240: return m_scr[2];
      12'h341: return m_epc;
      12'hC12: return IDV;
      12'h7B0: return m_dbg;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] md, input bit w, input logic [11:0] a);
    if (a == 12'h3C0) return "R7";
    if (a >= 12'h7B0 && a <= 12'h7BF) return "R8";
    if (a == 12'h341) return "R4";
    if (w && a[11:10] == 2'b11) return "R3";
    if (!mapped(a)) return "R10";
    return w ? "R11" : "R2";
  endfunction

  task automatic access(input logic [2:0] md, input bit w, input logic [11:0] a,
                        input logic [31:0] d, input string tag);
    bit ok;
    logic [31:0] ev;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; mode = md;
    #1;
    ok = exp_ok(md, w, a);
    ev = (ok && !w) ? exp_val(a) : 32'h0;
    chk({grant, illegal, rdata} == {ok, !ok, ev}, tag, {grant, illegal, rdata}, {ok, !ok, ev});
    if (ok && w) begin
      case (a)
        12'h040: m_scr[0] = d;
        12'h140: m_scr[1] = d;
        12'h240: m_scr[2] = d;
        12'h341: m_epc = {d[31:1], 1'b0};
        12'h7B0: m_dbg = d;
        12'h3C0: m_key = d;
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk(key == m_key, "R7", {2'b0, key}, {2'b0, m_key});
    req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) m_scr[i] = '0;
    m_epc = '0; m_dbg = '0; m_key = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values seen from debug mode
    access(3'd4, 0, 12'h040, 0, "R1");
    access(3'd4, 0, 12'h140, 0, "R1");
    access(3'd4, 0, 12'h240, 0, "R1");
    access(3'd4, 0, 12'h341, 0, "R1");
    access(3'd4, 0, 12'hC12, 0, "R1");
    access(3'd4, 0, 12'h7B0, 0, "R1");

    // R6: no request, no strobes
    @(negedge clk);
    req = 1'b0; we = 1'b1; addr = 12'h341; mode = 3'd3;
    #1;
    chk(!grant && !illegal, "R6", {grant, illegal, 32'h0}, 34'h0);

    // R9: odd write to exception PC, read back even
    access(3'd3, 1, 12'h341, 32'h8000_1235, "R9");
    access(3'd3, 0, 12'h341, 0, "R9");
    // R4 / R5: user read denied with zero data, then value unchanged
    access(3'd0, 0, 12'h341, 0, "R4");
    access(3'd2, 1, 12'h341, 32'hFFFF_FFFF, "R5");
    access(3'd4, 0, 12'h341, 0, "R5");
    // R3: ID write blocked, value kept
    access(3'd3, 1, 12'hC12, 32'h1111_1111, "R3");
    access(3'd0, 0, 12'hC12, 0, "R3");
    // R7: key write from machine, read back zero from user and machine
    access(3'd3, 1, 12'h3C0, 32'hCAFE_F00D, "R7");
    access(3'd0, 0, 12'h3C0, 0, "R7");
    access(3'd3, 0, 12'h3C0, 0, "R7");
    access(3'd1, 1, 12'h3C0, 32'h0BAD_0BAD, "R7");
    // R11: scratch write then read
    access(3'd0, 1, 12'h040, 32'h1234_5678, "R11");
    access(3'd0, 0, 12'h040, 0, "R11");

    // Exhaustive sweep: every mode code, address and direction
    for (int md = 0; md < 8; md++) begin
      for (int a = 0; a < 4096; a++) begin
        for (int w = 0; w < 2; w++) begin
          logic [11:0] av;
          logic [31:0] dv;
          av = 12'(a);
          dv = {av, 1'b0, 3'(md), av ^ 12'hA5C, 4'b1011};
          access(3'(md), w[0], av, dv, tag_of(3'(md), w[0], av));
        end
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule